// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. A down-counter runs once software enables it. When the counter reaches zero, the block raises a timeout interrupt and refills the counter from a load register. If a second timeout happens while the first interrupt is still pending, and reset generation is enabled, the block pulses a reset request. Software services the watchdog by rewriting the load register or by clearing the interrupt.

A write-protection lock guards the load and control registers against runaway code. Only one 32-bit key releases the lock, and any other value written to the lock register engages it. A test register holds a stall bit. When that bit is set, a debug-halt input freezes the counter, so a debugger pause does not cause a timeout.

The register interface is a simple single-cycle bus. Writes take effect on the clock edge where the write strobe is sampled high. Read data is combinational and is forced to zero whenever the read strobe is low.

Top module: `wdogTop`

## Requirements
- R1: After reset, the load register (0x000) and the counter value (0x004) both read 0xFFFFFFFF. Control (0x008), raw status (0x010), masked status (0x014), test (0x418) and lock (0xC00) all read 0, and both outputs are low.
- R2: Writing control bit0 = 1 starts the counter from the load register on that write edge. Control bit0 then reads back as 1.
- R3: While running, the counter decrements by one per cycle. On the cycle it is at zero it reloads from the load register and sets raw status bit0.
- R4: An accepted load write while the counter is running copies the written value into the counter on the same edge.
- R5: An accepted write of 0 to the load register sets raw status bit0 on that edge, whether or not the counter is running.
- R6: Masked status bit0 equals raw status bit0 AND control bit0. The interrupt output follows masked status.
- R7: Writing 1 in bit0 to the clear register (0x00C) clears raw status, and the interrupt output drops.
- R8: Writing any value other than 0x1ACCE551 to the lock register engages the lock, and the lock register then reads 1. While locked, writes to load and control are ignored.
- R9: Writing 0x1ACCE551 to the lock register releases the lock, and the lock register then reads 0.
- R10: With test bit8 (stall) set and the debug-halt input high, the counter holds its value. With stall clear, the counter keeps counting regardless of debug-halt.
- R11: A timeout that occurs while raw status is already set, with control bit1 (reset enable) set, raises the reset request output for exactly one cycle. That cycle is the one after the timeout edge.
- R12: Once control bit0 is set, writes cannot clear it. Only a system reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte address |
| busWdata | input | 32 | Write data |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busRead | input | 1 | Read strobe, enables read data |
| busRdata | output | 32 | Read data (combinational) |
| dbgHalt | input | 1 | Debugger halt indication |
| irqOut | output | 1 | Timeout interrupt (masked status) |
| resetReqOut | output | 1 | One-cycle system reset request |

## Verification
Most internal faults in this block show up at the ports within a few cycles.

- **Counter decrement:** A wrong decrement or reload appears in the value register on the very next read.
- **Timeout timing:** An off-by-one in zero detection shifts the interrupt edge by one cycle, which a bench counting cycles from the enable write catches.
- **Lock handling:** A lock that fails to engage shows up as a changed load or control readback right after the ignored write.
- **Reset request:** A wrong pending-status test misses the pulse, or fires it on the first timeout instead of the second. This becomes visible one cycle after the relevant timeout edge.

// File: rtl/wdogPkg.sv
package wdogPkg;
  parameter int WD_W = 32;
  parameter int WD_ADDR_W = 12;

  localparam logic [WD_ADDR_W-1:0] OFF_LOAD  = 12'h000;
  localparam logic [WD_ADDR_W-1:0] OFF_VALUE = 12'h004;
  localparam logic [WD_ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [WD_ADDR_W-1:0] OFF_CLEAR = 12'h00C;
  localparam logic [WD_ADDR_W-1:0] OFF_RAW   = 12'h010;
  localparam logic [WD_ADDR_W-1:0] OFF_MASK  = 12'h014;
  localparam logic [WD_ADDR_W-1:0] OFF_TEST  = 12'h418;
  localparam logic [WD_ADDR_W-1:0] OFF_LOCK  = 12'hC00;

  localparam logic [WD_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  // Strobes from the control side into the counter datapath
  typedef struct packed {
    logic            load;   // replace counter with value
    logic            tick;   // decrement when not loading
    logic [WD_W-1:0] value;
  } wdStrobe_t;
endpackage

// File: rtl/wdogCounter.sv
module wdogCounter
  import wdogPkg::*;
#(
  parameter int W = WD_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  wdStrobe_t    strobe,
  output logic [W-1:0] count,
  output logic         cntZero
);
  always_ff @(posedge clk) begin
    if (!rstN)            count <= '1;
    else if (strobe.load) count <= strobe.value;
    else if (strobe.tick) count <= count - 1'b1;
  end

  assign cntZero = (count == '0);

  // R10: without load or tick the counter must not move
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.tick) |=> $stable(count));

  // R4: a load strobe lands in the counter on the next edge
  assert_load_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(strobe.value)));
endmodule

// File: rtl/wdogRegs.sv
module wdogRegs
  import wdogPkg::*;
#(
  parameter int W = WD_W,
  parameter int AW = WD_ADDR_W,
  parameter int STALL_BIT = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [W-1:0]  busWdata,
  input  logic          busWrite,
  input  logic          busRead,
  output logic [W-1:0]  busRdata,
  input  logic          dbgHalt,
  input  logic [W-1:0]  count,
  input  logic          cntZero,
  output wdStrobe_t     strobe,
  output logic          irqOut,
  output logic          resetReqOut
);
  logic [W-1:0] loadReg;
  logic intEn, resEn, stallBit, locked, rawIrq, resetReq;

  logic wrLoad, wrCtrl, wrClear, wrTest, wrLock;
  logic loadAccept, ctrlAccept, reloadNow, enableRise, frozen, tick, expire;
  logic maskedIrq;

  assign wrLoad  = busWrite && (busAddr == OFF_LOAD);
  assign wrCtrl  = busWrite && (busAddr == OFF_CTRL);
  assign wrClear = busWrite && (busAddr == OFF_CLEAR);
  assign wrTest  = busWrite && (busAddr == OFF_TEST);
  assign wrLock  = busWrite && (busAddr == OFF_LOCK);

  assign loadAccept = wrLoad && !locked;
  assign ctrlAccept = wrCtrl && !locked;
  assign reloadNow  = loadAccept && intEn;
  assign enableRise = ctrlAccept && busWdata[0] && !intEn;
  assign frozen     = stallBit && dbgHalt;
  assign tick       = intEn && !frozen;
  assign expire     = tick && cntZero && !reloadNow;

  always_comb begin
    strobe.load  = reloadNow || enableRise || expire;
    strobe.tick  = tick;
    strobe.value = loadAccept ? busWdata : loadReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg  <= '1;
      intEn    <= 1'b0;
      resEn    <= 1'b0;
      stallBit <= 1'b0;
      locked   <= 1'b0;
      rawIrq   <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      if (loadAccept) loadReg <= busWdata;
      if (ctrlAccept) begin
        intEn <= intEn | busWdata[0];
        resEn <= busWdata[1];
      end
      if (wrTest) stallBit <= busWdata[STALL_BIT];
      if (wrLock) locked <= (busWdata != UNLOCK_KEY);
      if (expire || (loadAccept && busWdata == '0)) rawIrq <= 1'b1;
      else if (wrClear && busWdata[0])              rawIrq <= 1'b0;
      resetReq <= expire && rawIrq && resEn;
    end
  end

  assign maskedIrq   = rawIrq & intEn;
  assign irqOut      = maskedIrq;
  assign resetReqOut = resetReq;

  always_comb begin
    busRdata = '0;
    if (busRead) begin
      unique case (busAddr)
        OFF_LOAD:  busRdata = loadReg;
        OFF_VALUE: busRdata = count;
        OFF_CTRL:  busRdata = {{(W-2){1'b0}}, resEn, intEn};
        OFF_RAW:   busRdata = {{(W-1){1'b0}}, rawIrq};
        OFF_MASK:  busRdata = {{(W-1){1'b0}}, maskedIrq};
        OFF_TEST:  busRdata = W'(stallBit) << STALL_BIT;
        OFF_LOCK:  busRdata = {{(W-1){1'b0}}, locked};
        default:   busRdata = '0;
      endcase
    end
  end

  assert_enable_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    intEn |=> intEn);

  assert_locked_load_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wrLoad) |=> $stable(loadReg));

  assert_reset_needs_pending_R11: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(rawIrq));

  assert_clear_drops_raw_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrClear && busWdata[0] && !expire && !wrLoad) |=> !rawIrq);

  assert_stall_blocks_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stallBit && dbgHalt) |-> !strobe.tick);
endmodule

// File: rtl/wdogTop.sv
module wdogTop
  import wdogPkg::*;
#(
  parameter int W = WD_W,
  parameter int AW = WD_ADDR_W,
  parameter int STALL_BIT = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [W-1:0]  busWdata,
  input  logic          busWrite,
  input  logic          busRead,
  output logic [W-1:0]  busRdata,
  input  logic          dbgHalt,
  output logic          irqOut,
  output logic          resetReqOut
);
  wdStrobe_t    strobe;
  logic [W-1:0] count;
  logic         cntZero;

  wdogRegs #(.W(W), .AW(AW), .STALL_BIT(STALL_BIT)) uRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRead(busRead), .busRdata(busRdata),
    .dbgHalt(dbgHalt), .count(count), .cntZero(cntZero), .strobe(strobe),
    .irqOut(irqOut), .resetReqOut(resetReqOut)
  );

  wdogCounter #(.W(W)) uCounter (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count), .cntZero(cntZero)
  );
endmodule

// File: tb/tb_wdogTop.sv
module tb_wdogTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic        dbgHalt = 1'b0;
  logic        irqOut, resetReqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  wdogTop dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    busRead = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(12'h000, v); check("R1 load", v, 32'hFFFFFFFF);
    rd(12'h004, v); check("R1 value", v, 32'hFFFFFFFF);
    rd(12'h008, v); check("R1 ctrl", v, 0);
    rd(12'h010, v); check("R1 raw", v, 0);
    rd(12'h014, v); check("R1 masked", v, 0);
    rd(12'h418, v); check("R1 test", v, 0);
    rd(12'hC00, v); check("R1 lock", v, 0);
    check("R1 irq", irqOut, 0);
    check("R1 rstreq", resetReqOut, 0);
  endtask

  task automatic testZeroLoadMasked();
    logic [31:0] v;
    wr(12'h000, 0);
    rd(12'h010, v); check("R5 raw after zero load", v, 1);
    rd(12'h014, v); check("R6 masked with enable off", v, 0);
    check("R6 irq with enable off", irqOut, 0);
    wr(12'h00C, 1);
    rd(12'h010, v); check("R7 raw cleared", v, 0);
  endtask

  task automatic testTimeout();
    logic [31:0] v;
    wr(12'h000, 10);
    wr(12'h008, 1);
    rd(12'h004, v); check("R2 start from load", v, 10);
    rd(12'h008, v); check("R2 ctrl bit0", v, 1);
    waitCyc(10);
    rd(12'h004, v); check("R3 reached zero", v, 0);
    check("R3 no irq before expire", irqOut, 0);
    waitCyc(1);
    rd(12'h004, v); check("R3 reloaded", v, 10);
    rd(12'h010, v); check("R3 raw set", v, 1);
    rd(12'h014, v); check("R6 masked set", v, 1);
    check("R6 irq high", irqOut, 1);
    wr(12'h00C, 1);
    check("R7 irq dropped", irqOut, 0);
  endtask

  task automatic testReloadWrite();
    logic [31:0] v;
    wr(12'h000, 1000);
    rd(12'h004, v); check("R4 immediate reload", v, 1000);
  endtask

  task automatic testLock();
    logic [31:0] v;
    wr(12'hC00, 32'h0);
    rd(12'hC00, v); check("R8 locked code", v, 1);
    wr(12'h000, 5);
    rd(12'h000, v); check("R8 load ignored", v, 1000);
    wr(12'h008, 3);
    rd(12'h008, v); check("R8 ctrl ignored", v, 1);
    wr(12'hC00, 32'h1ACCE551);
    rd(12'hC00, v); check("R9 unlocked", v, 0);
    wr(12'h000, 700);
    rd(12'h000, v); check("R9 load accepted", v, 700);
  endtask

  task automatic testStall();
    logic [31:0] a, b;
    wr(12'h418, 32'h100);
    dbgHalt = 1'b1;
    @(negedge clk);
    rd(12'h004, a);
    waitCyc(5);
    rd(12'h004, b); check("R10 frozen", b, a);
    wr(12'h418, 0);
    rd(12'h004, a);
    waitCyc(5);
    rd(12'h004, b); check("R10 runs when stall clear", b, a - 5);
    dbgHalt = 1'b0;
  endtask

  task automatic testSticky();
    logic [31:0] v;
    wr(12'h008, 0);
    rd(12'h008, v); check("R12 enable sticky", v, 1);
  endtask

  task automatic testResetReq();
    logic [31:0] v;
    wr(12'h00C, 1);
    wr(12'h008, 3);
    wr(12'h000, 3);
    waitCyc(3);
    check("R11 no req yet", resetReqOut, 0);
    waitCyc(1);
    check("R3 first timeout irq", irqOut, 1);
    check("R11 no req on first timeout", resetReqOut, 0);
    waitCyc(4);
    check("R11 req on second timeout", resetReqOut, 1);
    waitCyc(1);
    check("R11 req one cycle", resetReqOut, 0);
    wr(12'h00C, 1);
    wr(12'h008, 1);
    wr(12'h000, 0);
    check("R5 zero load irq while running", irqOut, 1);
    rd(12'h010, v); check("R5 raw while running", v, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroLoadMasked();
    testTimeout();
    testReloadWrite();
    testLock();
    testStall();
    testSticky();
    testResetReq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule